// File: doc/BRIEF.md
# Masked Level Interrupt Controller

This block gathers a configurable number of level-sensitive interrupt request lines (96 by default) and presents them to a processor as a single interrupt output, reached through a simple 32-bit register bus. Every line carries one mask bit. The mask bits are organised in 32-bit groups. Software never writes a mask word directly. It sets bits through one alias register and clears bits through another, so two agents can change different lines without a read-modify-write race.

Request lines are registered once. Of the lines that are asserted and unmasked, the lowest-numbered one is latched as the active interrupt. The number stays frozen in the sorted-number register until software writes an acknowledge to the control register. When the frozen line has gone away before software reads it, the upper bits of that register flag the read as spurious.

A soft reset runs for a fixed number of cycles, and a done flag reports when it has finished. The block also holds an autoidle enable bit, a revision register and one 32-bit save/restore word per line.

Top module: `mirq_ctrl`

## Requirements
- R1: After the reset input, every mask group (offset 0x84 + 0x20·g) reads 0xFFFFFFFF and `irq_o` is low. The status register (0x14) reads 1, the config register (0x10) reads 0, and the sorted-number register (0x40) reads 0xFFFFFF80.
- R2: For group g, a write to 0x8C + 0x20·g sets the mask bits at the one-bits of the data, and a write to 0x88 + 0x20·g clears them. Zero bits leave the mask as it was, and a write to the mask word itself (0x84 + 0x20·g) changes nothing.
- R3: The pending word of group g (0x98 + 0x20·g) reads the lines of that group that are asserted and unmasked. Bit b of the word stands for line 32·g + b.
- R4: A masked line is never selected. An unmasked asserted line raises `irq_o` two clock edges after it rises.
- R5: Among asserted unmasked lines the lowest number is selected. Bits [6:0] of 0x40 hold that number, and they do not change while it awaits acknowledge, even if a lower line arrives.
- R6: Bits [31:7] of 0x40 read all ones when nothing is held, or when the held line is no longer both asserted and unmasked. Otherwise they read zero.
- R7: A write to 0x48 with bit 0 set releases the held interrupt, and `irq_o` falls at the next edge. A write to 0x48 with bit 0 clear has no effect.
- R8: Writing 1 to bit 1 of 0x10 starts a soft reset. Status bit 0 reads 0 for RST_CYCLES cycles and then reads 1 again. The soft reset masks all lines, drops the held interrupt, clears autoidle and clears the level words. Bus writes made while the soft reset runs are ignored.
- R9: Bit 0 of 0x10 is the autoidle enable. It reads back the last value written, and bit 1 always reads 0.
- R10: Offset 0x00 reads the revision, with the major number in bits [7:4] and the minor number in bits [3:0].
- R11: The word at 0x100 + 4·n, for line n, is a 32-bit read/write register. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | NUM_LINES | Level-sensitive request lines |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_o | output | 1 | Interrupt to the processor; high while an interrupt is held |

## Verification
The bench builds the block with the default 96 lines, which gives three mask groups and lets it drive lines on both sides of the group edges (2, 33, 40, 70, 95) and the top line 95, whose number fills all seven number bits. It shortens RST_CYCLES to 5, so the done flag can be watched low and high again, and a write made while the soft reset runs can be shown to be dropped. With three groups the stride decode is exercised beyond group 0 for the alias, pending and read-only mask words.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_REV   = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CFG   = 12'h010;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_SORT  = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h048;
  localparam logic [ADDR_W-1:0] GRP_BASE  = 12'h080;
  localparam logic [ADDR_W-1:0] LVL_BASE  = 12'h100;

  // sub-offsets inside one 0x20 group window
  localparam logic [4:0] SUB_MASK = 5'h04;
  localparam logic [4:0] SUB_CLR  = 5'h08;
  localparam logic [4:0] SUB_SET  = 5'h0C;
  localparam logic [4:0] SUB_PEND = 5'h18;
endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
  parameter int GRP_W    = 32,
  parameter int NUM_GRPS = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mask_all_i,
  input  logic [NUM_GRPS-1:0]       set_we_i,
  input  logic [NUM_GRPS-1:0]       clr_we_i,
  input  logic [GRP_W-1:0]          wdata_i,
  output logic [NUM_GRPS*GRP_W-1:0] mask_o
);
  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    logic [GRP_W-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          mask_q <= '1;
      else if (mask_all_i)  mask_q <= '1;
      else if (set_we_i[g]) mask_q <= mask_q | wdata_i;
      else if (clr_we_i[g]) mask_q <= mask_q & ~wdata_i;
    end
    assign mask_o[g*GRP_W +: GRP_W] = mask_q;
  end
endmodule

// File: rtl/intc_select.sv
module intc_select #(
  parameter int NUM_LINES = 96,
  parameter int ID_W      = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 flush_i,
  input  logic                 ack_i,
  output logic [NUM_LINES-1:0] active_o,
  output logic                 hold_o,
  output logic [ID_W-1:0]      sel_o,
  output logic                 spur_o
);
  localparam int PAD_N = 2 ** ID_W;

  logic [NUM_LINES-1:0] pend_q;
  logic                 hold_q;
  logic [ID_W-1:0]      sel_q, low_idx;
  logic [PAD_N-1:0]     act_pad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= lines_i;
  end

  assign active_o = pend_q & ~mask_i;

  // lowest-numbered active line wins
  always_comb begin
    low_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (active_o[i]) low_idx = ID_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      sel_q  <= '0;
    end else if (flush_i) begin
      hold_q <= 1'b0;
      sel_q  <= '0;
    end else if (hold_q) begin
      if (ack_i) hold_q <= 1'b0;
    end else if (|active_o) begin
      hold_q <= 1'b1;
      sel_q  <= low_idx;
    end
  end

  always_comb begin
    act_pad = '0;
    act_pad[NUM_LINES-1:0] = active_o;
  end

  assign hold_o = hold_q;
  assign sel_o  = sel_q;
  assign spur_o = !hold_q || !act_pad[sel_q];
endmodule

// File: rtl/intc_softrst.sv
module intc_softrst #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
    else if (start_i)            cnt_q <= CW'(RST_CYCLES);
  end

  assign busy_o = cnt_q != '0;
endmodule

// File: rtl/mirq_ctrl.sv
module mirq_ctrl
  import intc_pkg::*;
#(
  parameter int          NUM_LINES  = 96,
  parameter int          RST_CYCLES = 16,
  parameter logic [3:0]  REV_MAJOR  = 4'h2,
  parameter logic [3:0]  REV_MINOR  = 4'h1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  localparam int GRP_W    = DATA_W;
  localparam int NUM_GRPS = (NUM_LINES + GRP_W - 1) / GRP_W;
  localparam int GIW      = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1;
  localparam int ID_W     = $clog2(NUM_LINES);
  localparam logic [ADDR_W-1:0] GRP_SPAN = ADDR_W'(NUM_GRPS * 32);
  localparam logic [ADDR_W-1:0] LVL_SPAN = ADDR_W'(NUM_LINES * 4);

  logic                      soft_busy, wr, ack_w, cfg_wr;
  logic [ADDR_W-1:0]         grp_off, lvl_off;
  logic                      in_grp, in_lvl;
  logic [GIW-1:0]            grp_idx;
  logic [4:0]                grp_sub;
  logic [ID_W-1:0]           lvl_idx;
  logic [NUM_GRPS-1:0]       set_we, clr_we;
  logic [NUM_GRPS*GRP_W-1:0] mask_pad, act_pad;
  logic [NUM_LINES-1:0]      mask_lin, active;
  logic                      hold, spur;
  logic [ID_W-1:0]           sel;
  logic                      autoidle_q;
  logic [DATA_W-1:0]         lvl_q [NUM_LINES];

  // decode
  assign wr      = req_i && we_i && !soft_busy;
  assign grp_off = addr_i - GRP_BASE;
  assign lvl_off = addr_i - LVL_BASE;
  assign in_grp  = (addr_i >= GRP_BASE) && (grp_off < GRP_SPAN);
  assign in_lvl  = (addr_i >= LVL_BASE) && (lvl_off < LVL_SPAN);
  assign grp_idx = grp_off[5 +: GIW];
  assign grp_sub = grp_off[4:0];
  assign lvl_idx = lvl_off[2 +: ID_W];
  assign ack_w   = wr && (addr_i == OFF_CTRL) && wdata_i[0];
  assign cfg_wr  = wr && (addr_i == OFF_CFG);

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_dec
    assign set_we[g] = wr && in_grp && (grp_idx == GIW'(g)) && (grp_sub == SUB_SET);
    assign clr_we[g] = wr && in_grp && (grp_idx == GIW'(g)) && (grp_sub == SUB_CLR);
  end

  intc_softrst #(.RST_CYCLES(RST_CYCLES)) u_softrst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cfg_wr && wdata_i[1]),
    .busy_o  (soft_busy)
  );

  intc_mask_bank #(.GRP_W(GRP_W), .NUM_GRPS(NUM_GRPS)) u_mask (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_all_i (soft_busy),
    .set_we_i   (set_we),
    .clr_we_i   (clr_we),
    .wdata_i    (wdata_i),
    .mask_o     (mask_pad)
  );

  assign mask_lin = mask_pad[NUM_LINES-1:0];

  intc_select #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lines_i  (irq_lines_i),
    .mask_i   (mask_lin),
    .flush_i  (soft_busy),
    .ack_i    (ack_w),
    .active_o (active),
    .hold_o   (hold),
    .sel_o    (sel),
    .spur_o   (spur)
  );

  always_comb begin
    act_pad = '0;
    act_pad[NUM_LINES-1:0] = active;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        autoidle_q <= 1'b0;
    else if (soft_busy) autoidle_q <= 1'b0;
    else if (cfg_wr)    autoidle_q <= wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) lvl_q[i] <= '0;
    end else if (soft_busy) begin
      for (int i = 0; i < NUM_LINES; i++) lvl_q[i] <= '0;
    end else if (wr && in_lvl) begin
      lvl_q[lvl_idx] <= wdata_i;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i == OFF_REV)       rdata_o = {{(DATA_W-8){1'b0}}, REV_MAJOR, REV_MINOR};
      else if (addr_i == OFF_CFG)  rdata_o = {{(DATA_W-1){1'b0}}, autoidle_q};
      else if (addr_i == OFF_STAT) rdata_o = {{(DATA_W-1){1'b0}}, !soft_busy};
      else if (addr_i == OFF_SORT) rdata_o = {{(DATA_W-ID_W){spur}}, hold ? sel : '0};
      else if (in_grp) begin
        if (grp_sub == SUB_MASK)      rdata_o = mask_pad[grp_idx*GRP_W +: GRP_W];
        else if (grp_sub == SUB_PEND) rdata_o = act_pad[grp_idx*GRP_W +: GRP_W];
      end else if (in_lvl)         rdata_o = lvl_q[lvl_idx];
    end
  end

  assign irq_o = hold;
endmodule

// File: rtl/mirq_ctrl_chk.sv
module mirq_ctrl_chk #(
  parameter int NUM_LINES = 96,
  parameter int ID_W      = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 irq_o,
  input logic                 busy,
  input logic                 hold,
  input logic [ID_W-1:0]      sel,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] active,
  input logic                 ack
);
  p_ack_drops_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && hold) |=> !irq_o);

  p_sel_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && !ack && !busy) |=> (hold && $stable(sel)));

  p_take_needs_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold) |-> $past(active != '0));

  p_softrst_masks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ((&mask) && !irq_o));

  p_irq_follows_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(!busy));
endmodule

bind mirq_ctrl mirq_ctrl_chk #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_o  (irq_o),
  .busy   (soft_busy),
  .hold   (hold),
  .sel    (sel),
  .mask   (mask_lin),
  .active (active),
  .ack    (ack_w)
);

// File: tb/tb_mirq_ctrl.sv
module tb_mirq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 96;
  localparam int RSTC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            checks = 0, errs = 0;
  logic          done = 1'b0;

  mirq_ctrl #(.NUM_LINES(NL), .RST_CYCLES(RSTC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", r, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string r, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(r, d, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int g = 0; g < 3; g++) rd_chk("R1 mask", 12'(12'h084 + 32*g), 32'hFFFF_FFFF);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 status", 12'h014, 32'h1);
    rd_chk("R1 config", 12'h010, 32'h0);
    rd_chk("R1 sorted", 12'h040, 32'hFFFF_FF80);
    rd_chk("R10 revision", 12'h000, 32'h21);
  endtask

  task automatic t_masks();
    bus_wr(12'h0A8, 32'h0000_0005);
    rd_chk("R2 clear alias", 12'h0A4, 32'hFFFF_FFFA);
    bus_wr(12'h0AC, 32'h0000_0001);
    rd_chk("R2 set alias", 12'h0A4, 32'hFFFF_FFFB);
    bus_wr(12'h0A4, 32'h0);
    rd_chk("R2 mask word read-only", 12'h0A4, 32'hFFFF_FFFB);
    bus_wr(12'h0A8, 32'h0);
    bus_wr(12'h0AC, 32'h0);
    rd_chk("R2 zero bits no effect", 12'h0A4, 32'hFFFF_FFFB);
    bus_wr(12'h0AC, 32'hFFFF_FFFF);
  endtask

  task automatic t_select();
    lines[40] = 1'b1;
    wait_n(3);
    chk("R4 masked not taken", {31'b0, irq}, 32'h0);
    rd_chk("R3 pending masked", 12'h0B8, 32'h0);
    bus_wr(12'h0A8, 32'h0000_0100);
    wait_n(3);
    chk("R4 irq raised", {31'b0, irq}, 32'h1);
    rd_chk("R3 pending grp1", 12'h0B8, 32'h0000_0100);
    rd_chk("R5 sorted 40", 12'h040, 32'h28);
    bus_wr(12'h088, 32'h4);
    lines[2] = 1'b1;
    wait_n(3);
    rd_chk("R5 frozen vs lower line", 12'h040, 32'h28);
    bus_wr(12'h048, 32'h0);
    wait_n(2);
    rd_chk("R7 ack bit0 clear ignored", 12'h040, 32'h28);
    chk("R7 irq kept", {31'b0, irq}, 32'h1);
    bus_wr(12'h048, 32'h1);
    wait_n(2);
    rd_chk("R5 lowest after ack", 12'h040, 32'h02);
    lines[2] = 1'b0;
    wait_n(2);
    rd_chk("R6 vanished line", 12'h040, 32'hFFFF_FF82);
    bus_wr(12'h048, 32'h1);
    wait_n(2);
    rd_chk("R5 reselect 40", 12'h040, 32'h28);
    lines[95] = 1'b1;
    lines[40] = 1'b0;
    bus_wr(12'h0C8, 32'h8000_0000);
    bus_wr(12'h048, 32'h1);
    wait_n(3);
    rd_chk("R5 top line 95", 12'h040, 32'h5F);
    bus_wr(12'h0A8, 32'h2);
    bus_wr(12'h0C8, 32'h40);
    lines[33] = 1'b1; lines[70] = 1'b1; lines[95] = 1'b0;
    bus_wr(12'h048, 32'h1);
    wait_n(3);
    rd_chk("R5 lowest of 33/70", 12'h040, 32'h21);
    bus_wr(12'h0AC, 32'h2);
    wait_n(2);
    rd_chk("R6 masked after select", 12'h040, 32'hFFFF_FFA1);
    bus_wr(12'h048, 32'h1);
    wait_n(3);
    rd_chk("R5 next line 70", 12'h040, 32'h46);
    rd_chk("R3 pending grp2", 12'h0D8, 32'h0000_0040);
    lines = '0;
    bus_wr(12'h048, 32'h1);
    wait_n(3);
    chk("R7 irq released", {31'b0, irq}, 32'h0);
    rd_chk("R6 nothing held", 12'h040, 32'hFFFF_FF80);
  endtask

  task automatic t_level_cfg();
    bus_wr(12'h100, 32'hDEAD_BEEF);
    bus_wr(12'h27C, 32'h1234_5678);
    rd_chk("R11 level line0", 12'h100, 32'hDEAD_BEEF);
    rd_chk("R11 level line95", 12'h27C, 32'h1234_5678);
    rd_chk("R11 unmapped", 12'h300, 32'h0);
    bus_wr(12'h010, 32'h1);
    rd_chk("R9 autoidle set", 12'h010, 32'h1);
    bus_wr(12'h010, 32'h0);
    rd_chk("R9 autoidle clear", 12'h010, 32'h0);
    bus_wr(12'h010, 32'h1);
  endtask

  task automatic t_softrst();
    lines[2] = 1'b1;
    wait_n(3);
    chk("R4 held before soft reset", {31'b0, irq}, 32'h1);
    bus_wr(12'h010, 32'h2);
    rd_chk("R8 busy status", 12'h014, 32'h0);
    bus_wr(12'h0C8, 32'hFFFF_FFFF);
    wait_n(RSTC + 2);
    rd_chk("R8 done status", 12'h014, 32'h1);
    rd_chk("R8 mask0 restored", 12'h084, 32'hFFFF_FFFF);
    rd_chk("R8 write during reset ignored", 12'h0C4, 32'hFFFF_FFFF);
    chk("R8 held dropped", {31'b0, irq}, 32'h0);
    rd_chk("R8 autoidle cleared", 12'h010, 32'h0);
    rd_chk("R8 level cleared", 12'h100, 32'h0);
    lines = '0;
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_masks();
    t_select();
    t_level_cfg();
    t_softrst();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule